// File: doc/BRIEF.md
# Byte-Serial Multiprecision Arithmetic Sequencer

This block carries out add, subtract, one-bit logical shift and one-bit rotate on operands of 1 to `MAX_LEN` bytes that sit in a small internal byte memory. It handles one byte per step. A single carry flag is the only link between one byte step and the next. A command names the operation, a source base address, a destination base address and a length in bytes. The result replaces the destination operand. When the last byte has been written, the block pulses `done`, and the final carry (or borrow) stays on `carry`.

Operands are stored most significant byte first. The byte at the base address is the most significant, and the byte at base + length - 1 is the least significant. Addresses wrap modulo the memory depth. Add, subtract, left shift and left rotate walk from the least significant byte upward. Right shift and right rotate walk from the most significant byte downward. The first step of a sequence differs from the later steps: for add, subtract and the logical shifts it takes no carry in, while for the rotates it uses the carry flag left by the previous command. A host port loads and inspects the memory while the sequencer is idle.

Top module: `mp_byte_seq`

## Requirements
- R1: Opcode 0 (add) sets dst := (dst + src) mod 2^(8L). The carry flag ends as the carry out of the most significant byte. The least significant byte is added with no carry in.
- R2: Opcode 1 (subtract) sets dst := (dst - src) mod 2^(8L). The carry flag ends as a borrow: 1 exactly when dst < src as unsigned L-byte numbers. The least significant byte is subtracted with no borrow in.
- R3: Opcode 2 (left shift) shifts the L-byte dst left by one bit, fills bit 0 of the least significant byte with 0, and sets carry to the old bit 7 of the byte at the base address.
- R4: Opcode 3 (right shift) shifts dst right by one bit, fills bit 7 of the byte at the base address with 0, and sets carry to the old bit 0 of the least significant byte.
- R5: Opcode 4 (left rotate) and opcode 5 (right rotate) act like R3 and R4, except that the filled bit takes the carry flag's value from before the command. The carry then receives the bit shifted out.
- R6: A command is rejected if its opcode is 6 or 7, or if its length is 0 or greater than `MAX_LEN`. `done` rises on the cycle after acceptance, and neither memory nor the carry flag changes.
- R7: A legal command of L bytes keeps `busy` high from the cycle after acceptance. `done` is first high 3*L cycles after the accepting edge and stays high for exactly one cycle, with `busy` low at that time.
- R8: Only the compute step of each byte changes the carry flag. The flag keeps its final value until the next command is accepted. Memory bytes outside the destination span are never written.
- R9: A command presented while `busy` is high is ignored and does not change the running operation.
- R10: A host write (`host_we`) takes effect at the clock edge only while the block is idle and is ignored while busy. `host_rdata` always shows the byte at `host_addr` combinationally.
- R11: After reset, `busy`, `done` and `carry` are 0 and every memory byte is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe, accepted when idle |
| cmd_op | input | 3 | Operation code (0 add, 1 sub, 2 shl, 3 shr, 4 rol, 5 ror) |
| cmd_src | input | ADDR_W | Source operand base address (most significant byte) |
| cmd_dst | input | ADDR_W | Destination operand base address (most significant byte) |
| cmd_len | input | $clog2(MAX_LEN+1) | Operand length in bytes |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion or rejection pulse |
| carry | output | 1 | Carry / borrow flag |
| host_we | input | 1 | Host memory write enable |
| host_addr | input | ADDR_W | Host memory address |
| host_wdata | input | DATA_W | Host write data |
| host_rdata | output | DATA_W | Memory byte at host_addr |

## Verification
Assertions check on every cycle that the carry flag moves only on the edge that ends a compute step and that a command arriving during a sequence leaves the latched operation unchanged. They also check that the step index stays within the operand span, that a rejected command never starts a sequence, and that the final write is followed by a single `done` with `busy` low. Whether the arithmetic is right, whether each operation walks in the correct direction, whether the first step is special and whether rotates seed from the earlier carry can only be seen from the bench's sweeps. The bench compares every memory byte and the flag with values it computes from the whole operands taken as numbers, using ripple-heavy patterns and chained commands.

// File: rtl/mpseq_pkg.sv
package mpseq_pkg;

   typedef enum logic [2:0] {
      OP_ADD = 3'd0,
      OP_SUB = 3'd1,
      OP_SHL = 3'd2,
      OP_SHR = 3'd3,
      OP_ROL = 3'd4,
      OP_ROR = 3'd5
   } op_e;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_FETCH,
      ST_CALC,
      ST_STORE
   } st_e;

   function automatic logic op_legal(input logic [2:0] code);
      return code <= 3'd5;
   endfunction

   // true for the operations that start at the most significant byte
   function automatic logic op_msb_first(input op_e o);
      return (o == OP_SHR) || (o == OP_ROR);
   endfunction

endpackage

// File: rtl/mpseq_step_alu.sv
module mpseq_step_alu
   import mpseq_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  op_e               op,
   input  logic              first,
   input  logic              cin,
   input  logic [DATA_W-1:0] dbyte,
   input  logic [DATA_W-1:0] sbyte,
   output logic [DATA_W-1:0] res,
   output logic              cout
);

   logic [DATA_W:0] wide;
   logic            link;

   always_comb begin
      // plain first step for add, sub and logical shifts
      link = first ? 1'b0 : cin;
      wide = '0;
      res  = dbyte;
      cout = cin;
      unique case (op)
         OP_ADD: begin
            wide = {1'b0, dbyte} + {1'b0, sbyte} + {{DATA_W{1'b0}}, link};
            res  = wide[DATA_W-1:0];
            cout = wide[DATA_W];
         end
         OP_SUB: begin
            // top bit of the widened difference is the borrow out
            wide = {1'b0, dbyte} - {1'b0, sbyte} - {{DATA_W{1'b0}}, link};
            res  = wide[DATA_W-1:0];
            cout = wide[DATA_W];
         end
         OP_SHL: begin
            res  = {dbyte[DATA_W-2:0], link};
            cout = dbyte[DATA_W-1];
         end
         OP_ROL: begin
            res  = {dbyte[DATA_W-2:0], cin};
            cout = dbyte[DATA_W-1];
         end
         OP_SHR: begin
            res  = {link, dbyte[DATA_W-1:1]};
            cout = dbyte[0];
         end
         OP_ROR: begin
            res  = {cin, dbyte[DATA_W-1:1]};
            cout = dbyte[0];
         end
         default: begin
            res  = dbyte;
            cout = cin;
         end
      endcase
   end

endmodule

// File: rtl/mpseq_addr_gen.sv
module mpseq_addr_gen #(
   parameter int ADDR_W = 4,
   parameter int LEN_W  = 4
) (
   input  logic [ADDR_W-1:0] src_base,
   input  logic [ADDR_W-1:0] dst_base,
   input  logic [LEN_W-1:0]  len,
   input  logic [LEN_W-1:0]  idx,
   input  logic              msb_first,
   output logic [ADDR_W-1:0] src_addr,
   output logic [ADDR_W-1:0] dst_addr
);

   logic [LEN_W-1:0]  offset;
   logic [ADDR_W-1:0] off_a;

   // step k touches byte base+k going down in weight, or base+len-1-k going up
   assign offset = msb_first ? idx : (len - LEN_W'(1) - idx);

   generate
      if (LEN_W >= ADDR_W) begin : g_trunc
         assign off_a = offset[ADDR_W-1:0];
      end else begin : g_ext
         assign off_a = {{(ADDR_W-LEN_W){1'b0}}, offset};
      end
   endgenerate

   assign src_addr = src_base + off_a;
   assign dst_addr = dst_base + off_a;

endmodule

// File: rtl/mpseq_byte_ram.sv
module mpseq_byte_ram #(
   parameter int DATA_W         = 8,
   parameter int ADDR_W         = 4,
   parameter bit CLEAR_ON_RESET = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [ADDR_W-1:0] raddr_a,
   output logic [DATA_W-1:0] rdata_a,
   input  logic [ADDR_W-1:0] raddr_b,
   output logic [DATA_W-1:0] rdata_b,
   input  logic [ADDR_W-1:0] raddr_c,
   output logic [DATA_W-1:0] rdata_c
);

   localparam int DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] mem [DEPTH];

   generate
      if (CLEAR_ON_RESET) begin : g_clear
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
            end else if (we) begin
               mem[waddr] <= wdata;
            end
         end
      end else begin : g_keep
         always_ff @(posedge clk) begin
            if (we) mem[waddr] <= wdata;
         end
      end
   endgenerate

   assign rdata_a = mem[raddr_a];
   assign rdata_b = mem[raddr_b];
   assign rdata_c = mem[raddr_c];

endmodule

// File: rtl/mp_byte_seq.sv
module mp_byte_seq
   import mpseq_pkg::*;
#(
   parameter int DATA_W  = 8,
   parameter int ADDR_W  = 4,
   parameter int MAX_LEN = 8,
   localparam int LEN_W  = $clog2(MAX_LEN + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   input  logic [2:0]        cmd_op,
   input  logic [ADDR_W-1:0] cmd_src,
   input  logic [ADDR_W-1:0] cmd_dst,
   input  logic [LEN_W-1:0]  cmd_len,
   output logic              busy,
   output logic              done,
   output logic              carry,
   input  logic              host_we,
   input  logic [ADDR_W-1:0] host_addr,
   input  logic [DATA_W-1:0] host_wdata,
   output logic [DATA_W-1:0] host_rdata
);

   localparam int DEPTH = 1 << ADDR_W;

   initial begin
      assert (DATA_W >= 2) else $error("DATA_W must be at least 2");
      assert (MAX_LEN >= 1) else $error("MAX_LEN must be at least 1");
      assert (MAX_LEN <= DEPTH) else $error("MAX_LEN exceeds memory depth");
   end

   st_e               state;
   op_e               op_q;
   logic [ADDR_W-1:0] src_q, dst_q;
   logic [LEN_W-1:0]  len_q, idx_q;
   logic [DATA_W-1:0] dbyte_q, res_q;
   logic              carry_q, done_q;

   logic              accept, legal, last_step, eng_we;
   logic [ADDR_W-1:0] src_addr, dst_addr, waddr;
   logic [DATA_W-1:0] rd_dst, rd_src, wdata, alu_res;
   logic              alu_cout;

   assign accept    = cmd_valid && (state == ST_IDLE);
   assign legal     = op_legal(cmd_op) && (cmd_len != '0)
                      && (cmd_len <= LEN_W'(MAX_LEN));
   assign last_step = (idx_q == len_q - LEN_W'(1));
   assign eng_we    = (state == ST_STORE);

   mpseq_addr_gen #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_addr (
      .src_base (src_q),
      .dst_base (dst_q),
      .len      (len_q),
      .idx      (idx_q),
      .msb_first(op_msb_first(op_q)),
      .src_addr (src_addr),
      .dst_addr (dst_addr)
   );

   // host writes land only while idle
   assign waddr = eng_we ? dst_addr : host_addr;
   assign wdata = eng_we ? res_q : host_wdata;

   mpseq_byte_ram #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .CLEAR_ON_RESET(1'b1)) u_ram (
      .clk    (clk),
      .rst_n  (rst_n),
      .we     (eng_we || (host_we && state == ST_IDLE)),
      .waddr  (waddr),
      .wdata  (wdata),
      .raddr_a(dst_addr),
      .rdata_a(rd_dst),
      .raddr_b(src_addr),
      .rdata_b(rd_src),
      .raddr_c(host_addr),
      .rdata_c(host_rdata)
   );

   mpseq_step_alu #(.DATA_W(DATA_W)) u_alu (
      .op   (op_q),
      .first(idx_q == '0),
      .cin  (carry_q),
      .dbyte(dbyte_q),
      .sbyte(rd_src),
      .res  (alu_res),
      .cout (alu_cout)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         op_q    <= OP_ADD;
         src_q   <= '0;
         dst_q   <= '0;
         len_q   <= LEN_W'(1);
         idx_q   <= '0;
         dbyte_q <= '0;
         res_q   <= '0;
         carry_q <= 1'b0;
         done_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         unique case (state)
            ST_IDLE: begin
               if (accept) begin
                  if (legal) begin
                     op_q  <= op_e'(cmd_op);
                     src_q <= cmd_src;
                     dst_q <= cmd_dst;
                     len_q <= cmd_len;
                     idx_q <= '0;
                     state <= ST_FETCH;
                  end else begin
                     done_q <= 1'b1;
                  end
               end
            end
            ST_FETCH: begin
               dbyte_q <= rd_dst;
               state   <= ST_CALC;
            end
            ST_CALC: begin
               res_q   <= alu_res;
               carry_q <= alu_cout;
               state   <= ST_STORE;
            end
            ST_STORE: begin
               if (last_step) begin
                  state  <= ST_IDLE;
                  done_q <= 1'b1;
               end else begin
                  idx_q <= idx_q + LEN_W'(1);
                  state <= ST_FETCH;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign busy  = (state != ST_IDLE);
   assign done  = done_q;
   assign carry = carry_q;

   // R8: flag moves only on the edge that closes a compute step
   p_carry_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (state != ST_CALC) |=> $stable(carry_q));

   // R9: a command during a sequence leaves the latched operation alone
   p_ignore_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && cmd_valid) |=> ($stable(op_q) && $stable(len_q)
                               && $stable(src_q) && $stable(dst_q)));

   // R7: final write is followed by a done with busy dropped
   p_done_after_last_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_STORE && last_step) |=> (done && !busy));

   // R7: step index never leaves the operand span
   p_idx_in_span_r7: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (idx_q < len_q));

   // R6: a rejected command never starts a sequence
   p_reject_no_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && !legal) |=> (!busy && done));

   // R7: done is never raised while a sequence runs
   p_done_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

endmodule

// File: tb/sim_mp_byte_seq.sv
module sim_mp_byte_seq;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cmd_valid = 1'b0;
   logic [2:0] cmd_op = '0;
   logic [3:0] cmd_src = '0, cmd_dst = '0, cmd_len = '0;
   logic       busy, done, carry;
   logic       host_we = 1'b0;
   logic [3:0] host_addr = '0;
   logic [7:0] host_wdata = '0, host_rdata;

   always #10 clk = ~clk;   // 50 MHz

   mp_byte_seq #(.DATA_W(8), .ADDR_W(4), .MAX_LEN(8)) u0 (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
      .cmd_src(cmd_src), .cmd_dst(cmd_dst), .cmd_len(cmd_len),
      .busy(busy), .done(done), .carry(carry),
      .host_we(host_we), .host_addr(host_addr),
      .host_wdata(host_wdata), .host_rdata(host_rdata)
   );

   int         n_chk = 0, n_bad = 0, cyc = 0;
   logic [7:0] mdl [16];
   logic       mcarry = 1'b0;
   logic [31:0] rs = 32'h1234_5678;

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic logic [7:0] rnd8();
      rs = rs ^ (rs << 13);
      rs = rs ^ (rs >> 17);
      rs = rs ^ (rs << 5);
      return rs[7:0];
   endfunction

   function automatic string tag_of(input int op);
      case (op)
         0: return "R1";
         1: return "R2";
         2: return "R3";
         3: return "R4";
         4, 5: return "R5";
         default: return "R6";
      endcase
   endfunction

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual %0d expected below %0d", cyc, 150000);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   task automatic load_mem();
      for (int a = 0; a < 16; a++) begin
         @(negedge clk);
         host_we = 1'b1; host_addr = 4'(a); host_wdata = mdl[a];
      end
      @(negedge clk);
      host_we = 1'b0;
   endtask

   task automatic check_mem(input string req);
      int bad_at = -1;
      logic [7:0] got = '0;
      for (int a = 0; a < 16; a++) begin
         host_addr = 4'(a);
         #1;
         if (host_rdata !== mdl[a] && bad_at < 0) begin
            bad_at = a; got = host_rdata;
         end
      end
      chk(bad_at < 0, req, $sformatf("memory byte %0d", bad_at),
          got, (bad_at < 0) ? 0 : mdl[bad_at]);
   endtask

   task automatic exec(input int op, input int src, input int dst,
                       input int len, input bit intrude);
      bit          legal;
      int          bits, lat;
      logic [64:0] vd, vs, r, mask;
      logic        c;
      string       t;
      t     = tag_of(op);
      legal = (op <= 5) && (len >= 1) && (len <= 8);
      c     = mcarry;
      if (legal) begin
         bits = 8 * len;
         mask = (65'd1 << bits) - 65'd1;
         vd = '0; vs = '0;
         for (int i = 0; i < len; i++) begin
            vd = (vd << 8) | 65'(mdl[(dst + i) & 15]);
            vs = (vs << 8) | 65'(mdl[(src + i) & 15]);
         end
         case (op)
            0: begin r = vd + vs; c = r[bits]; end
            1: begin c = (vd < vs); r = vd - vs; end
            2: begin c = vd[bits-1]; r = vd << 1; end
            3: begin c = vd[0]; r = vd >> 1; end
            4: begin r = (vd << 1) | 65'(mcarry); c = vd[bits-1]; end
            default: begin r = (vd >> 1) | (65'(mcarry) << (bits - 1)); c = vd[0]; end
         endcase
         r = r & mask;
         for (int i = 0; i < len; i++)
            mdl[(dst + i) & 15] = 8'(r >> (8 * (len - 1 - i)));
      end
      @(negedge clk);
      cmd_op = 3'(op); cmd_src = 4'(src); cmd_dst = 4'(dst); cmd_len = 4'(len);
      cmd_valid = 1'b1;
      @(negedge clk);
      cmd_valid = 1'b0;
      lat = 0;
      while (!done && lat < 100) begin
         @(negedge clk);
         lat++;
         if (intrude && lat == 2) begin
            // R9 / R10: command and host write during busy must be ignored
            cmd_valid = 1'b1; cmd_op = 3'd1; cmd_len = 4'd1;
            host_we = 1'b1; host_addr = 4'((dst + len) & 15); host_wdata = 8'h5A;
         end else if (intrude && lat == 3) begin
            cmd_valid = 1'b0; host_we = 1'b0;
         end
      end
      chk(lat == (legal ? 3 * len : 0), legal ? "R7" : "R6", "done latency",
          lat, legal ? 3 * len : 0);
      @(negedge clk);
      chk(!done, "R7", "done pulse width", done, 0);
      chk(carry === c, t, $sformatf("carry op%0d len%0d", op, len), carry, c);
      check_mem(intrude ? "R9/R10" : t);
      mcarry = c;
      repeat (3) @(negedge clk);
      chk(carry === c, "R8", "carry held while idle", carry, c);
   endtask

   task automatic fill(input int pat, input int src, input int dst, input int len);
      for (int a = 0; a < 16; a++) mdl[a] = rnd8();
      for (int i = 0; i < len; i++) begin
         case (pat)
            1: begin
               mdl[(dst + i) & 15] = 8'hFF;
               mdl[(src + i) & 15] = (i == len - 1) ? 8'h01 : 8'h00;
            end
            2: begin
               mdl[(dst + i) & 15] = 8'h00;
               mdl[(src + i) & 15] = (i == len - 1) ? 8'h01 : 8'h00;
            end
            3: begin
               mdl[(dst + i) & 15] = i[0] ? 8'h01 : 8'h80;
               mdl[(src + i) & 15] = i[0] ? 8'h80 : 8'h01;
            end
            default: ;
         endcase
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R11: reset state
      chk(!busy && !done && !carry, "R11", "status after reset",
          {busy, done, carry}, 0);
      for (int a = 0; a < 16; a++) mdl[a] = '0;
      check_mem("R11");

      // R10: idle host writes take effect
      for (int a = 0; a < 16; a++) mdl[a] = rnd8();
      load_mem();
      check_mem("R10");

      // sweep: every length, op and pattern; carry chains across commands
      for (int len = 1; len <= 8; len++)
         for (int pat = 0; pat < 4; pat++)
            for (int op = 0; op < 6; op++) begin
               int dst = (len * 5 + pat * 3) & 15;
               int src = (dst + 8) & 15;
               fill(pat, src, dst, len);
               load_mem();
               exec(op, src, dst, len, 1'b0);
            end

      // src and dst identical: doubling by add
      fill(0, 3, 3, 4);
      load_mem();
      exec(0, 3, 3, 4, 1'b0);

      // R6: rejected commands keep memory and flag
      fill(0, 8, 0, 4);
      load_mem();
      exec(0, 8, 0, 0, 1'b0);
      exec(1, 8, 0, 9, 1'b0);
      exec(6, 8, 0, 3, 1'b0);
      exec(7, 8, 0, 15, 1'b0);

      // R9, R10: intrusion while busy
      fill(0, 12, 4, 6);
      load_mem();
      exec(0, 12, 4, 6, 1'b1);
      exec(5, 12, 4, 6, 1'b1);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule